// File: doc/BRIEF.md
# Operand-Isolating Functional Unit Wrapper

This block places an add/subtract functional unit of a shared datapath behind a set of operand holding registers. The two operand buses come from multiplexed register outputs, and their values change whenever the datapath steers other traffic. The holding registers take a new operand pair and a new operation select only in a cycle where the controller raises the execute strobe. In every other cycle the unit's inputs stay frozen, so an idle unit sees no input switching.

Two counters add up how many operand bits actually toggle at the unit's inputs. A parameter selects between the isolating variant and a plain variant whose registers load every cycle. That makes the saving measurable by running the same stimulus on both.

Top module: `fu_iso_wrap`

## Requirements
- R1: With isolation enabled (ISOLATE=1), an edge where exec_en is high loads opnd_a, opnd_b and op_sel into the unit's operand registers.
- R2: With isolation enabled, edges where exec_en is low leave the operand registers unchanged. Any activity on opnd_a, opnd_b or op_sel in idle cycles then changes neither result nor the toggle counts.
- R3: op_sel = 0 selects addition. The result is (a + b) modulo 2^WIDTH.
- R4: op_sel = 1 selects subtraction. The result is (a - b) modulo 2^WIDTH, and a borrow wraps around.
- R5: When exec_en is sampled high at clock edge k, result takes the new value at edge k+2. At that same edge result_vld goes high for exactly one cycle. Back-to-back strobes give back-to-back results.
- R6: result keeps its value in every cycle where result_vld is low.
- R7: tgl_a and tgl_b accumulate the Hamming distance between successive values of the A and B operand registers. An operand reused by consecutive operations adds zero.
- R8: With ISOLATE=0, the operand registers load on every edge, so the toggle counts follow all input activity. Results still appear only per R5 and match the isolating variant.
- R9: A synchronous active-high rst clears the operand registers, result, result_vld and both toggle counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | WIDTH | First operand from the datapath multiplexer |
| opnd_b | input | WIDTH | Second operand from the datapath multiplexer |
| exec_en | input | 1 | Controller strobe: this cycle is a scheduled operation |
| op_sel | input | 1 | 0 = add, 1 = subtract |
| result | output | WIDTH | Held result of the last operation |
| result_vld | output | 1 | One-cycle pulse when result carries a new value |
| tgl_a | output | TCNT_W | Accumulated bit toggles at operand A of the unit |
| tgl_b | output | TCNT_W | Accumulated bit toggles at operand B of the unit |

## Verification
The embedded assertions check the per-cycle invariants on every clock. Operand registers follow their inputs after a strobe and stay stable without one. result_vld is never raised without a strobe two edges earlier, result holds while result_vld is low, and a counter never grows by more than WIDTH per edge. The arithmetic values, the exact Hamming totals and the reuse of a shared operand can only be shown by the bench scenarios. The same holds for the immunity of an idle unit to multiplexer noise and for the contrast with the always-loading variant. The bench runs both variants side by side on one stimulus and compares their results and toggle counts with its own model.

// File: rtl/fu_iso_pkg.sv
package fu_iso_pkg;
   typedef enum logic {
      FU_ADD = 1'b0,
      FU_SUB = 1'b1
   } fu_op_e;
endpackage

// File: rtl/operand_hold.sv
module operand_hold #(
   parameter int W       = 16,
   parameter bit ISOLATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         exec,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic load;

   generate
      if (ISOLATE) begin : g_gated
         assign load = exec;
      end else begin : g_free
         assign load = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   // R1: a strobe captures the presented value
   assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
      exec |=> (q == $past(d)));

   generate
      if (ISOLATE) begin : g_chk
         // R2: no strobe, no movement at the unit input
         assert_frozen_R2: assert property (@(posedge clk) disable iff (rst)
            !exec |=> $stable(q));
      end
   endgenerate
endmodule

// File: rtl/fu_core.sv
module fu_core
   import fu_iso_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  fu_op_e       op,
   output logic [W-1:0] y
);
   always_comb begin
      unique case (op)
         FU_ADD:  y = a + b;
         FU_SUB:  y = a - b;
         default: y = a + b;
      endcase
   end
endmodule

// File: rtl/toggle_tally.sv
module toggle_tally #(
   parameter int W  = 16,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  sig,
   output logic [CW-1:0] cnt
);
   localparam int PW = $clog2(W + 1);

   logic [W-1:0]  prev;
   logic [W-1:0]  diff;
   logic [PW-1:0] hd;

   assign diff = sig ^ prev;

   always_comb begin
      hd = '0;
      for (int i = 0; i < W; i++) hd = hd + PW'(diff[i]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev <= '0;
         cnt  <= '0;
      end else begin
         prev <= sig;
         cnt  <= cnt + CW'(hd);
      end
   end

   // R7: one edge adds at most W toggles
   assert_step_R7: assert property (@(posedge clk) disable iff (rst)
      (cnt - $past(cnt)) <= CW'(W));
endmodule

// File: rtl/fu_iso_wrap.sv
module fu_iso_wrap
   import fu_iso_pkg::*;
#(
   parameter int WIDTH   = 16,
   parameter int TCNT_W  = 32,
   parameter bit ISOLATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WIDTH-1:0]  opnd_a,
   input  logic [WIDTH-1:0]  opnd_b,
   input  logic              exec_en,
   input  logic              op_sel,
   output logic [WIDTH-1:0]  result,
   output logic              result_vld,
   output logic [TCNT_W-1:0] tgl_a,
   output logic [TCNT_W-1:0] tgl_b
);
   localparam int MIN_CNT_W = $clog2(WIDTH + 1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("fu_iso_wrap: WIDTH must be at least 2");
      end
      if (TCNT_W < MIN_CNT_W) begin : g_bad_cnt
         $error("fu_iso_wrap: TCNT_W too narrow for one step");
      end
   endgenerate

   logic [WIDTH-1:0] a_q, b_q, y;
   logic [0:0]       op_q;
   logic             exec_d;

   operand_hold #(.W(WIDTH), .ISOLATE(ISOLATE)) u_hold_a (
      .clk(clk), .rst(rst), .exec(exec_en), .d(opnd_a), .q(a_q));
   operand_hold #(.W(WIDTH), .ISOLATE(ISOLATE)) u_hold_b (
      .clk(clk), .rst(rst), .exec(exec_en), .d(opnd_b), .q(b_q));
   operand_hold #(.W(1), .ISOLATE(ISOLATE)) u_hold_op (
      .clk(clk), .rst(rst), .exec(exec_en), .d(op_sel), .q(op_q));

   fu_core #(.W(WIDTH)) u_core (
      .a(a_q), .b(b_q), .op(fu_op_e'(op_q[0])), .y(y));

   always_ff @(posedge clk) begin
      if (rst) begin
         exec_d     <= 1'b0;
         result     <= '0;
         result_vld <= 1'b0;
      end else begin
         exec_d     <= exec_en;
         result_vld <= exec_d;
         if (exec_d) result <= y;
      end
   end

   toggle_tally #(.W(WIDTH), .CW(TCNT_W)) u_tally_a (
      .clk(clk), .rst(rst), .sig(a_q), .cnt(tgl_a));
   toggle_tally #(.W(WIDTH), .CW(TCNT_W)) u_tally_b (
      .clk(clk), .rst(rst), .sig(b_q), .cnt(tgl_b));

   // R5: a valid pulse always traces back to a strobe two edges earlier
   assert_vld_origin_R5: assert property (@(posedge clk) disable iff (rst)
      result_vld |-> $past(exec_en, 2));

   // R6: result is held whenever no new value is flagged
   assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !result_vld |-> $stable(result));
endmodule

// File: tb/tb_fu_iso_wrap.sv
module tb_fu_iso_wrap;
   localparam int W  = 16;
   localparam int CW = 32;

   typedef struct {
      logic [W-1:0] val;
      int           cyc;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic exec = 1'b0, sub = 1'b0;

   logic [W-1:0]  res, res_r;
   logic          vld, vld_r;
   logic [CW-1:0] ta, tb, ta_r, tb_r;

   int checks = 0, errors = 0, cyc = 0;
   exp_t q[$];
   int exp_ta = 0, exp_tb = 0, ref_ta = 0, ref_tb = 0;
   logic [W-1:0] ma = '0, mb = '0, pa = '0, pb = '0;

   always #5 clk = ~clk;

   fu_iso_wrap #(.WIDTH(W), .TCNT_W(CW), .ISOLATE(1'b1)) dut (
      .clk(clk), .rst(rst), .opnd_a(a_in), .opnd_b(b_in), .exec_en(exec),
      .op_sel(sub), .result(res), .result_vld(vld), .tgl_a(ta), .tgl_b(tb));

   fu_iso_wrap #(.WIDTH(W), .TCNT_W(CW), .ISOLATE(1'b0)) dut_ref (
      .clk(clk), .rst(rst), .opnd_a(a_in), .opnd_b(b_in), .exec_en(exec),
      .op_sel(sub), .result(res_r), .result_vld(vld_r), .tgl_a(ta_r), .tgl_b(tb_r));

   function automatic int popc(input logic [W-1:0] v);
      int n = 0;
      for (int i = 0; i < W; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // bench model of the always-loading variant input activity (R8)
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst) begin
         pa = '0; pb = '0; ref_ta = 0; ref_tb = 0;
      end else begin
         ref_ta += popc(a_in ^ pa); pa = a_in;
         ref_tb += popc(b_in ^ pb); pb = b_in;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst) begin
         if (vld) begin
            exp_t e;
            if (q.size() == 0) check(1'b0, "R5 unexpected valid", 1, 0);
            else begin
               e = q.pop_front();
               check(res == e.val, "R3/R4 result", res, e.val);
               check(cyc == e.cyc, "R5 latency", cyc, e.cyc);
            end
         end
         check(vld_r == vld, "R8 valid match", vld_r, vld);
         if (vld) check(res_r == res, "R8 result match", res_r, res);
      end
   end

   task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit s);
      exp_t e;
      @(negedge clk);
      a_in = a; b_in = b; sub = s; exec = 1'b1;
      e.val = s ? (a - b) : (a + b);
      e.cyc = cyc + 2;
      q.push_back(e);
      exp_ta += popc(a ^ ma); ma = a;
      exp_tb += popc(b ^ mb); mb = b;
   endtask

   task automatic idle(input int n, input bit noisy);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         exec = 1'b0;
         if (noisy) begin
            a_in = W'(i * 16'h3A5D + 16'h1234);
            b_in = ~W'(i * 16'h0F31);
            sub  = i[0];
         end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0]  r_snap;
      logic [CW-1:0] a_snap, b_snap;
      repeat (3) @(negedge clk);
      a_in = 16'hFFFF; b_in = 16'hAAAA; // reset must mask the inputs
      @(negedge clk);
      // R9: reset state
      check(res == '0, "R9 result", res, 0);
      check(vld == 1'b0, "R9 valid", vld, 0);
      check(ta == '0 && tb == '0, "R9 toggles", ta, 0);
      a_in = '0; b_in = '0;
      rst = 1'b0;
      idle(2, 1'b0);
      check(ta == '0 && tb == '0, "R9 toggles after release", ta, 0);

      do_op(16'd3, 16'd4, 1'b0);       // R3
      do_op(16'd10, 16'd3, 1'b1);      // R4, back to back (R5)
      do_op(16'd0, 16'd1, 1'b1);       // R4 borrow wraps to FFFF
      do_op(16'hFFFF, 16'd1, 1'b0);    // R3 carry wraps to 0
      idle(4, 1'b0);

      // R7: reuse of operand A adds no A toggles
      a_snap = ta; b_snap = tb;
      do_op(16'hFFFF, 16'h00F0, 1'b0);
      idle(4, 1'b0);
      check(ta == a_snap, "R7 reused operand", ta, a_snap);
      check(tb - b_snap == CW'(popc(16'h0001 ^ 16'h00F0)), "R7 changed operand",
            tb - b_snap, popc(16'h0001 ^ 16'h00F0));

      // R2: noisy idle multiplexer outputs
      r_snap = res; a_snap = ta; b_snap = tb;
      idle(20, 1'b1);
      idle(3, 1'b0);
      check(res == r_snap, "R2 result untouched", res, r_snap);
      check(ta == a_snap && tb == b_snap, "R2 toggles untouched", ta, a_snap);
      // R6: result held through idle cycles
      check(vld == 1'b0, "R6 no spurious valid", vld, 0);

      // R1: next op uses newly presented operands, not idle noise
      do_op(16'h1234, 16'h0234, 1'b1);
      do_op(16'h8000, 16'h8000, 1'b0);
      idle(5, 1'b0);

      check(q.size() == 0, "R5 all results delivered", q.size(), 0);
      check(ta == CW'(exp_ta), "R7 A toggle total", ta, exp_ta);
      check(tb == CW'(exp_tb), "R7 B toggle total", tb, exp_tb);
      check(ta_r == CW'(ref_ta), "R8 free-running A toggles", ta_r, ref_ta);
      check(tb_r == CW'(ref_tb), "R8 free-running B toggles", tb_r, ref_tb);
      check(ta_r + tb_r > ta + tb, "R8 isolation saves toggles", ta_r + tb_r, ta + tb);

      // R9: synchronous reset mid-run
      @(negedge clk); rst = 1'b1;
      @(negedge clk);
      check(res == '0 && ta == '0 && tb == '0, "R9 reset clears", res, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule